// File: doc/BRIEF.md
# Serial Loopback Configuration Sequencer

This block moves one transceiver lane into internal serial loopback, or back out of it, without software. It drives a memory-mapped register master and the lane's TX and RX reset requests. A start pulse launches one of three operations, chosen by `op_i`:

- **enable**: enter loopback.
- **disable**: leave loopback.
- **relink**: reset a lane that is already looping back. Both resets are pulsed, the loopback bit is cleared during the reset, and it is set again afterwards.

Every configuration command reaches the lane through a two-phase mailbox exchange. Each phase is confirmed by polling a status register. Readiness of the RX side is polled before the loopback path is selected.

Each operation runs through an internal list of numbered steps. A wait on a reset acknowledge and a status poll are each one step. Every such wait is bounded by a cycle budget, `timeout_i`. When a wait runs out, the sequencer stops and reports the step at which it stopped. Completion is signalled by a one-cycle `done_o` pulse.

Top module: `lpbk_seq`

## Requirements
- R1: A start pulse (`start_i` high for one cycle) while `busy_o` is low begins an operation, and `busy_o` is high from the following cycle until completion or error. A start pulse while `busy_o` is high is ignored, and the running operation and its write trace are unchanged. `op_i` encodes 1 = enable, 2 = relink, and 0 or 3 = disable.
- R2: Every operation first drives `tx_rst_o` and `rx_rst_o` high together. No bus read or write is issued until both acknowledges are high.
- R3: Each command word is sent in two phases, and each phase is confirmed by polling the status address 0xA4040:
  - First, the word is written to address 0xA403C with bit 15 set, and the status is polled until bits [15:14] read 2'b10.
  - Then the same word is written with bit 15 clear, and the status is polled until bits [15:14] read 2'b00.
  - Other status bits are ignored.
- R4: Enable sends the command words 0xF9A00F, 0xF9200F, 0x00A003, 0x002003, 0x06A040, 0x062040 in that order. Disable sends the same first four words, then 0x00A040 and 0x002040.
- R5: After the last command, both resets are released. No further bus access happens until both acknowledges are low. `done_o` is never high while a reset is driven.
- R6: After the reset release, enable and relink poll address 0xA00D8 until bit 20 is 1, and then poll address 0x97814 until bit 0 is 1. Only then do they touch the path or loopback registers.
- R7: Enable ends with two read-modify-writes that keep all other bits of their registers:
  - clear bit 28 of address 0x919B4;
  - then set bit 1 of address 0x9781C.
- R8: Relink runs the following steps in order:
  - assert both resets and wait for both acknowledges;
  - clear bit 1 of 0x9781C by read-modify-write;
  - release the resets and wait for both acknowledges to drop;
  - repeat the two readiness polls of R6;
  - clear bit 28 of 0x919B4;
  - set bit 1 of 0x9781C.
- R9: While a bus request is stalled by `mm_waitrequest_i`, its address, write data and read/write strobes stay stable. Read and write are never high together.
- R10: Waits have a time limit. If a reset-acknowledge wait, or a poll completed after at least `timeout_i` cycles in its step, has not met its condition, the sequencer goes idle without `done_o`. It then raises `err_o` and shows in `err_code_o` the index of the failing step, counted from 0 within the operation. The index is 0 for the first reset wait and 2 for the first status poll. `err_o` stays high until the next accepted start.
- R11: On success, `done_o` is high for exactly one cycle, with `busy_o` low and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| op_i | input | 2 | Operation: 1 enable, 2 relink, else disable |
| timeout_i | input | TW | Cycle budget for each wait step |
| tx_rst_o | output | 1 | TX reset request |
| rx_rst_o | output | 1 | RX reset request |
| tx_rst_ack_i | input | 1 | TX reset acknowledge |
| rx_rst_ack_i | input | 1 | RX reset acknowledge |
| mm_addr_o | output | 20 | Bus address |
| mm_read_o | output | 1 | Bus read strobe |
| mm_write_o | output | 1 | Bus write strobe |
| mm_wdata_o | output | 32 | Bus write data |
| mm_rdata_i | input | 32 | Bus read data, valid when read is accepted |
| mm_waitrequest_i | input | 1 | Bus stall |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout error flag |
| err_code_o | output | 5 | Index of the step that timed out |

## Verification
Some properties are checked on every cycle by the assertions:
- request stability under a stall, and read/write exclusivity;
- no bus traffic while a reset acknowledge disagrees with its request;
- the one-cycle shape of `done_o`, and resets released at completion;
- `err_o` and `busy_o` being mutually exclusive.

The ordering of the mailbox phases, the exact command words, and the bits preserved by the read-modify-writes can only be shown by the bench. It runs a register-file lane model with random stalls, random handshake latencies and random register contents. It then compares the full write trace against a list computed from the requirements. The timeout codes, and the ignoring of a start pulse mid-run, are shown by directed scenarios.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;

  localparam logic [ADDR_W-1:0] A_CMD   = 20'hA403C;
  localparam logic [ADDR_W-1:0] A_STAT  = 20'hA4040;
  localparam logic [ADDR_W-1:0] A_RXRST = 20'hA00D8;
  localparam logic [ADDR_W-1:0] A_RXST  = 20'h97814;
  localparam logic [ADDR_W-1:0] A_PATH  = 20'h919B4;
  localparam logic [ADDR_W-1:0] A_LPBK  = 20'h9781C;

  typedef enum logic [1:0] {OP_DISABLE = 2'd0, OP_ENABLE = 2'd1, OP_RELINK = 2'd2} op_e;
  typedef enum logic [2:0] {K_RST_ON, K_RST_OFF, K_WR, K_POLL, K_RMW, K_END} kind_e;

  // POLL: (rd & mask) == data ; RMW: (rd & ~mask) | (data & mask)
  typedef struct packed {
    kind_e             kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] mask;
  } step_t;
endpackage

// File: rtl/lpbk_step_rom.sv
module lpbk_step_rom
  import lpbk_pkg::*;
(
  input  logic [1:0]       op_i,
  input  logic [IDX_W-1:0] idx_i,
  output step_t            step_o
);
  function automatic step_t mk(kind_e k, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                               logic [DATA_W-1:0] m);
    step_t s;
    s.kind = k; s.addr = a; s.data = d; s.mask = m;
    return s;
  endfunction

  localparam logic [DATA_W-1:0] HS_BIT  = 32'h0000_8000;
  localparam logic [DATA_W-1:0] HS_MASK = 32'h0000_C000;

  logic [IDX_W-1:0]  k;
  logic [DATA_W-1:0] base;

  always_comb begin
    k = idx_i - 1'b1;
    case (k[3:2])
      2'd0:    base = 32'h00F9_200F;
      2'd1:    base = 32'h0000_2003;
      default: base = (op_i == OP_ENABLE) ? 32'h0006_2040 : 32'h0000_2040;
    endcase
  end

  always_comb begin
    step_o = mk(K_END, '0, '0, '0);
    if (op_i == OP_RELINK) begin
      case (int'(idx_i))
        0: step_o = mk(K_RST_ON, '0, '0, '0);
        1: step_o = mk(K_RMW, A_LPBK, '0, 32'h2);
        2: step_o = mk(K_RST_OFF, '0, '0, '0);
        3: step_o = mk(K_POLL, A_RXRST, 32'h0010_0000, 32'h0010_0000);
        4: step_o = mk(K_POLL, A_RXST, 32'h1, 32'h1);
        5: step_o = mk(K_RMW, A_PATH, '0, 32'h1000_0000);
        6: step_o = mk(K_RMW, A_LPBK, 32'h2, 32'h2);
        default: ;
      endcase
    end else if (idx_i == '0) begin
      step_o = mk(K_RST_ON, '0, '0, '0);
    end else if (int'(idx_i) <= 12) begin
      case (k[1:0])
        2'd0: step_o = mk(K_WR, A_CMD, base | HS_BIT, '0);
        2'd1: step_o = mk(K_POLL, A_STAT, HS_BIT, HS_MASK);
        2'd2: step_o = mk(K_WR, A_CMD, base, '0);
        default: step_o = mk(K_POLL, A_STAT, '0, HS_MASK);
      endcase
    end else if (int'(idx_i) == 13) begin
      step_o = mk(K_RST_OFF, '0, '0, '0);
    end else if (op_i == OP_ENABLE) begin
      case (int'(idx_i))
        14: step_o = mk(K_POLL, A_RXRST, 32'h0010_0000, 32'h0010_0000);
        15: step_o = mk(K_POLL, A_RXST, 32'h1, 32'h1);
        16: step_o = mk(K_RMW, A_PATH, '0, 32'h1000_0000);
        17: step_o = mk(K_RMW, A_LPBK, 32'h2, 32'h2);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lpbk_mm_master.sv
module lpbk_mm_master #(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mm_addr_o,
  output logic          mm_read_o,
  output logic          mm_write_o,
  output logic [DW-1:0] mm_wdata_o,
  input  logic [DW-1:0] mm_rdata_i,
  input  logic          mm_waitrequest_i
);
  logic active;
  assign active = mm_read_o | mm_write_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mm_addr_o  <= '0;
      mm_wdata_o <= '0;
      mm_read_o  <= 1'b0;
      mm_write_o <= 1'b0;
      ack_o      <= 1'b0;
      rdata_o    <= '0;
    end else begin
      ack_o <= 1'b0;
      if (active) begin
        if (!mm_waitrequest_i) begin
          mm_read_o  <= 1'b0;
          mm_write_o <= 1'b0;
          ack_o      <= 1'b1;
          rdata_o    <= mm_rdata_i;
        end
      end else if (req_i) begin
        mm_addr_o  <= addr_i;
        mm_wdata_o <= wdata_i;
        mm_read_o  <= !we_i;
        mm_write_o <= we_i;
      end
    end
  end

  p_hold_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && mm_waitrequest_i |=> $stable(mm_addr_o) && $stable(mm_wdata_o)
                                   && $stable(mm_read_o) && $stable(mm_write_o));
  p_rw_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mm_read_o && mm_write_o));
endmodule

// File: rtl/lpbk_poll_timer.sv
module lpbk_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt <= '0;
    else if (clr_i)         cnt <= '0;
    else if (cnt != '1)     cnt <= cnt + 1'b1;
  end

  assign expired_o = cnt >= limit_i;
endmodule

// File: rtl/lpbk_seq.sv
module lpbk_seq
  import lpbk_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [TW-1:0]     timeout_i,
  output logic              tx_rst_o,
  output logic              rx_rst_o,
  input  logic              tx_rst_ack_i,
  input  logic              rx_rst_ack_i,
  output logic [ADDR_W-1:0] mm_addr_o,
  output logic              mm_read_o,
  output logic              mm_write_o,
  output logic [DATA_W-1:0] mm_wdata_o,
  input  logic [DATA_W-1:0] mm_rdata_i,
  input  logic              mm_waitrequest_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [IDX_W-1:0]  err_code_o
);
  typedef enum logic [2:0] {S_IDLE, S_STEP, S_RWAIT, S_WACK, S_PRD, S_MRD} state_e;

  state_e            state;
  logic [1:0]        op_q;
  logic [IDX_W-1:0]  idx;
  logic              rst_q;
  step_t             step;
  logic              req, we, ack, expired, match;
  logic [DATA_W-1:0] wdat, rdata;

  lpbk_step_rom u_rom (.op_i(op_q), .idx_i(idx), .step_o(step));

  lpbk_mm_master #(.AW(ADDR_W), .DW(DATA_W)) u_mst (
    .clk_i, .rst_ni, .req_i(req), .we_i(we), .addr_i(step.addr), .wdata_i(wdat),
    .ack_o(ack), .rdata_o(rdata), .mm_addr_o, .mm_read_o, .mm_write_o, .mm_wdata_o,
    .mm_rdata_i, .mm_waitrequest_i);

  lpbk_poll_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .clr_i(state == S_STEP), .limit_i(timeout_i), .expired_o(expired));

  assign match = (rdata & step.mask) == step.data;

  always_comb begin
    req  = 1'b0;
    we   = 1'b0;
    wdat = step.data;
    case (state)
      S_STEP: begin
        req = step.kind inside {K_WR, K_POLL, K_RMW};
        we  = step.kind == K_WR;
      end
      S_PRD: req = ack && !match && !expired;  // re-poll
      S_MRD: begin
        req  = ack;
        we   = 1'b1;
        wdat = (rdata & ~step.mask) | (step.data & step.mask);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= S_IDLE;
      op_q       <= OP_DISABLE;
      idx        <= '0;
      rst_q      <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      err_code_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          op_q  <= op_i;
          idx   <= '0;
          err_o <= 1'b0;
          state <= S_STEP;
        end
        S_STEP: case (step.kind)
          K_RST_ON:  begin rst_q <= 1'b1; state <= S_RWAIT; end
          K_RST_OFF: begin rst_q <= 1'b0; state <= S_RWAIT; end
          K_WR:      state <= S_WACK;
          K_POLL:    state <= S_PRD;
          K_RMW:     state <= S_MRD;
          default:   begin done_o <= 1'b1; state <= S_IDLE; end
        endcase
        S_RWAIT: if (tx_rst_ack_i == rst_q && rx_rst_ack_i == rst_q) begin
          idx   <= idx + 1'b1;
          state <= S_STEP;
        end else if (expired) begin
          err_o      <= 1'b1;
          err_code_o <= idx;
          state      <= S_IDLE;
        end
        S_WACK: if (ack) begin
          idx   <= idx + 1'b1;
          state <= S_STEP;
        end
        S_PRD: if (ack) begin
          if (match) begin
            idx   <= idx + 1'b1;
            state <= S_STEP;
          end else if (expired) begin
            err_o      <= 1'b1;
            err_code_o <= idx;
            state      <= S_IDLE;
          end
        end
        S_MRD: if (ack) state <= S_WACK;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign tx_rst_o = rst_q;
  assign rx_rst_o = rst_q;
  assign busy_o   = state != S_IDLE;

  p_start_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o && !err_o);
  p_bus_acked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_read_o || mm_write_o) |-> tx_rst_ack_i == tx_rst_o && rx_rst_ack_i == rx_rst_o);
  p_done_released_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tx_rst_o && !rx_rst_o);
  p_err_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !done_o);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tb_lpbk_seq.sv
module tb_lpbk_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_in = 2'd0;
  logic [15:0] tmo = 16'd1000;
  logic        tx_rst, rx_rst;
  logic        ack_tx = 1'b0, ack_rx = 1'b0;
  logic [19:0] mm_addr;
  logic        mm_rd, mm_wr;
  logic [31:0] mm_wdata;
  logic [31:0] mm_rdata = '0;
  logic        mm_wait = 1'b0;
  logic        busy, done, err;
  logic [4:0]  err_code;

  always #5 clk = ~clk;

  lpbk_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op_in), .timeout_i(tmo),
    .tx_rst_o(tx_rst), .rx_rst_o(rx_rst), .tx_rst_ack_i(ack_tx), .rx_rst_ack_i(ack_rx),
    .mm_addr_o(mm_addr), .mm_read_o(mm_rd), .mm_write_o(mm_wr), .mm_wdata_o(mm_wdata),
    .mm_rdata_i(mm_rdata), .mm_waitrequest_i(mm_wait),
    .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(err_code));

  int errors = 0, checks = 0;

  // lane model
  logic [31:0] r_path, r_lpbk, noise;
  logic        rx_out = 0, rx_st = 0;
  logic [1:0]  stat = 2'b00, stat_tgt = 2'b00;
  int          stat_cnt = 0, ack_cnt = 0, rdy_cnt = 0, wp = 0;
  bit          stuck_ack = 0, stuck_stat = 0;
  int          nlog = 0, done_cnt = 0;
  int          v_bus = 0, v_hold = 0, v_hs = 0, v_rdy = 0;
  logic [19:0] log_a [64];
  logic [31:0] log_d [64];
  logic [19:0] exp_a [32];
  logic [31:0] exp_d [32];
  int          exp_n;
  bit          hold_prev = 0;
  logic [19:0] pa;
  logic [31:0] pd;
  logic        prd, pwr;

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (hold_prev && (mm_addr != pa || mm_wdata != pd || mm_rd != prd || mm_wr != pwr)) v_hold++;
    if (mm_rd && mm_wr) v_hold++;
    if ((mm_rd || mm_wr) && (tx_rst != ack_tx || rx_rst != ack_rx)) v_bus++;
    mm_wait = (mm_rd || mm_wr) && (($urandom % 4) < wp);
    hold_prev = mm_wait; pa = mm_addr; pd = mm_wdata; prd = mm_rd; pwr = mm_wr;
    if ((mm_rd || mm_wr) && !mm_wait) begin
      if (mm_wr) begin
        if (nlog < 64) begin log_a[nlog] = mm_addr; log_d[nlog] = mm_wdata; end
        nlog++;
        case (mm_addr)
          20'hA403C: begin
            if (stat != (mm_wdata[15] ? 2'b00 : 2'b10)) v_hs++;
            stat = 2'b01; stat_tgt = {mm_wdata[15], 1'b0}; stat_cnt = $urandom % 6;
          end
          20'h919B4: begin if (!(rx_out && rx_st)) v_rdy++; r_path = mm_wdata; end
          20'h9781C: r_lpbk = mm_wdata;
          default: ;
        endcase
      end else begin
        case (mm_addr)
          20'hA4040: mm_rdata = {noise[31:16], stat, noise[13:0]};
          20'hA00D8: mm_rdata = {noise[31:21], rx_out, noise[19:0]};
          20'h97814: mm_rdata = {noise[31:1], rx_st};
          20'h919B4: mm_rdata = r_path;
          20'h9781C: mm_rdata = r_lpbk;
          default:   mm_rdata = noise;
        endcase
      end
    end
    if (stat_cnt > 0) stat_cnt--;
    else if (!stuck_stat && stat == 2'b01) stat = stat_tgt;
    if (!stuck_ack && (tx_rst != ack_tx || rx_rst != ack_rx)) begin
      if (ack_cnt == 0) begin ack_tx = tx_rst; ack_rx = rx_rst; ack_cnt = $urandom % 4; end
      else ack_cnt--;
    end
    if (tx_rst || ack_tx) begin rx_out = 0; rx_st = 0; rdy_cnt = 2 + $urandom % 6; end
    else if (rdy_cnt > 0) rdy_cnt--;
    else if (!rx_out) begin rx_out = 1; rdy_cnt = $urandom % 5; end
    else rx_st = 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build_exp(input logic [1:0] op, input logic [31:0] s_path, input logic [31:0] s_lpbk);
    logic [31:0] w [6];
    w[0] = 32'hF9A00F; w[1] = 32'hF9200F; w[2] = 32'h00A003; w[3] = 32'h002003;
    w[4] = (op == 2'd1) ? 32'h06A040 : 32'h00A040;
    w[5] = (op == 2'd1) ? 32'h062040 : 32'h002040;
    exp_n = 0;
    if (op == 2'd2) begin
      exp_a[0] = 20'h9781C; exp_d[0] = s_lpbk & ~32'h2;
      exp_a[1] = 20'h919B4; exp_d[1] = s_path & ~32'h1000_0000;
      exp_a[2] = 20'h9781C; exp_d[2] = s_lpbk | 32'h2;
      exp_n = 3;
    end else begin
      for (int i = 0; i < 6; i++) begin exp_a[i] = 20'hA403C; exp_d[i] = w[i]; end
      exp_n = 6;
      if (op == 2'd1) begin
        exp_a[6] = 20'h919B4; exp_d[6] = s_path & ~32'h1000_0000;
        exp_a[7] = 20'h9781C; exp_d[7] = s_lpbk | 32'h2;
        exp_n = 8;
      end
    end
  endtask

  task automatic launch(input logic [1:0] op, input bit poke, output int cyc);
    @(negedge clk) start = 1; op_in = op;
    @(negedge clk) start = 0;
    chk(busy == 1'b1, "R1 busy after start", 32'(busy), 1);
    cyc = 0;
    while (!done && !err && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 10) begin start = 1; op_in = op ^ 2'b01; end
      else start = 0;
    end
    start = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] op, input int wpr, input bit poke);
    logic [31:0] s_path, s_lpbk;
    int cyc;
    string tag;
    tag = (op == 2'd1) ? "R4 R7 enable" : (op == 2'd2) ? "R8 relink" : "R4 disable";
    s_path = $urandom; s_lpbk = $urandom; noise = $urandom;
    r_path = s_path; r_lpbk = s_lpbk; wp = wpr; tmo = 16'd1000;
    nlog = 0; done_cnt = 0; v_bus = 0; v_hold = 0; v_hs = 0; v_rdy = 0;
    build_exp(op, s_path, s_lpbk);
    launch(op, poke, cyc);
    chk(done_cnt == 1, "R11 done single pulse", 32'(done_cnt), 1);
    chk(!err && !busy, "R11 clean finish", {30'd0, err, busy}, 0);
    chk(nlog == exp_n, {tag, " write count"}, 32'(nlog), 32'(exp_n));
    for (int i = 0; i < exp_n && i < nlog; i++)
      chk(log_a[i] == exp_a[i] && log_d[i] == exp_d[i], {tag, " write trace"},
          {log_a[i][11:0], log_d[i][19:0]}, {exp_a[i][11:0], exp_d[i][19:0]});
    chk(v_hs == 0, "R3 handshake phase order", 32'(v_hs), 0);
    chk(v_bus == 0, "R2 R5 bus only when resets acked", 32'(v_bus), 0);
    chk(v_rdy == 0, "R6 readiness before path write", 32'(v_rdy), 0);
    chk(v_hold == 0, "R9 stalled request stable", 32'(v_hold), 0);
    chk(!tx_rst && !rx_rst, "R5 resets released", {30'd0, tx_rst, rx_rst}, 0);
    if (poke) chk(nlog == exp_n, "R1 mid-run start ignored", 32'(nlog), 32'(exp_n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'd2024));
    noise = 32'h0; r_path = 32'h0; r_lpbk = 32'h0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !tx_rst && !rx_rst && !mm_rd && !mm_wr, "R1 reset state",
        {25'd0, busy, done, err, tx_rst, rx_rst, mm_rd, mm_wr}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_op(2'd1, 0, 0);
    run_op(2'd0, 2, 0);
    run_op(2'd2, 1, 0);
    run_op(2'd1, 3, 1);
    run_op(2'd3, 1, 0);
    for (int i = 0; i < 6; i++) run_op(2'($urandom % 3), $urandom % 4, i[0]);

    // R10: reset acknowledge never arrives
    stuck_ack = 1; nlog = 0; done_cnt = 0; tmo = 16'd30; wp = 1;
    launch(2'd1, 0, cyc);
    chk(err == 1'b1 && !busy, "R10 ack timeout flag", {30'd0, err, busy}, 32'h2);
    chk(err_code == 5'd0, "R10 ack timeout code", 32'(err_code), 0);
    chk(done_cnt == 0 && nlog == 0, "R10 no done, no writes", 32'(done_cnt + nlog), 0);
    stuck_ack = 0;
    repeat (10) @(negedge clk);

    // R10: mailbox never answers
    stuck_stat = 1; nlog = 0; done_cnt = 0; tmo = 16'd40;
    launch(2'd1, 0, cyc);
    chk(err == 1'b1 && !busy, "R10 poll timeout flag", {30'd0, err, busy}, 32'h2);
    chk(err_code == 5'd2, "R10 poll timeout code", 32'(err_code), 2);
    chk(nlog == 1 && done_cnt == 0, "R10 stop after first command", 32'(nlog), 1);
    stuck_stat = 0; stat = 2'b00; stat_cnt = 0;
    repeat (5) @(negedge clk);

    run_op(2'd1, 2, 0);
    chk(!err, "R10 error cleared by next start", 32'(err), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule